// File: doc/BRIEF.md
# Secondary Code Overlay Unit

This unit holds two secondary (overlay) codes of up to 256 chips each. Once per primary code period it steps through both codes and gives the sign that the correlator outputs of a tracking channel must take. Each output bit is 0 for no inversion and 1 for inversion. The host loads each code as a series of packed words through a register of its own. It sets both code lengths with one combined register. It drives a control register that turns the overlay on and off and can restart both code indices without releasing the channel.

A single-cycle primary-epoch pulse advances the unit. On each pulse, while the overlay is on, the output register takes the chip at each code's current index and each index moves to the next chip. The register write port is a plain one-cycle strobe with a 2-bit register select and 32 bits of data. The unit does not generate the primary code, does not correlate, and does not implement a host bus.

Top module: `ovl_overlay_unit`

## Requirements
- R1: After reset the overlay is off, both sign outputs are 0, both indices are 0, and both programmed lengths are one chip.
- R2: Register select 1 writes the lengths. Bits 7:0 hold the code-0 length minus one and bits 15:8 hold the code-1 length minus one.
- R3: Register select 2 loads code 0 and select 3 loads code 1. Each load word carries 20 chips in bits 19:0, with the lowest-numbered chip in bit 0. Bits 23:20 give the word index, so the word covers chips 20*index to 20*index+19. Bit 31 is the strobe that commits the word.
- R4: A load word with bit 31 clear, or with a word index of 13 or more, leaves the stored code unchanged.
- R5: The last word of a code may carry fewer than 20 valid chips (the length modulo 20, or 20 when that is zero). Chips beyond the programmed length never reach the outputs.
- R6: Register select 0 is control: bit 0 turns the overlay on and bit 1 clears both indices. Writing 3 sets both indices and both sign outputs to 0 on the next cycle and leaves the overlay on.
- R7: Writing control value 1 keeps the overlay on and preserves both indices, so the chip sequence continues where it stopped.
- R8: Writing control value 0 turns the overlay off (ovl_en_o low, samples blocked). Both sign outputs read 0 from the next cycle, and epoch pulses neither advance the indices nor change the outputs.
- R9: On an epoch pulse while the overlay is on, each sign output takes its code's chip at the current index, one cycle after the pulse. The index then advances. Without an epoch pulse or a control write, the sign outputs hold.
- R10: An index that has reached its programmed length minus one wraps to 0 on the next epoch.
- R11: The two codes are stored, indexed and wrapped independently, each with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 2 | Register select: 0 control, 1 lengths, 2 code 0 load, 3 code 1 load |
| wr_data_i | input | 32 | Register write data |
| epoch_i | input | 1 | Primary code epoch pulse |
| ovl_en_o | output | 1 | Overlay on; low means samples are blocked |
| ovl_sgn0_o | output | 1 | Current code-0 chip; 1 inverts the correlator sign |
| ovl_sgn1_o | output | 1 | Current code-1 chip; 1 inverts the correlator sign |

## Verification
Every result sits one register away from its cause. The sign outputs follow an epoch pulse, and both ovl_en_o and the cleared signs follow a control write, all at the very next rising edge. The bench drives each write or epoch on a falling edge, removes it on the next falling edge, and samples the outputs at that same point, half a cycle after the edge that registered them. The expected chip pair for each epoch comes from a bench-side model built from the packing, length, control and wrap rules. This model is walked along long runs so that both codes wrap several times at different lengths.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    // register select codes of the write port
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_CODE0 = 2'd2,
        SEL_CODE1 = 2'd3
    } ovl_sel_e;

    // control register bit positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;

    // number of overlay codes held by the unit
    localparam int unsigned NUM_CODES = 2;

endpackage

// File: rtl/ovl_code_store.sv
module ovl_code_store #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned WORD_BITS  = 20,
    parameter int unsigned NWORDS     = 13,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned STROBE_BIT = 31,
    parameter int unsigned IDX_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_bit_o
);

    localparam int unsigned STORE_W = NWORDS * WORD_BITS;
    localparam int unsigned RD_W    = $clog2(STORE_W);

    logic [STORE_W-1:0] mem_d, mem_q;
    logic [ADDR_W-1:0]  waddr;
    logic [RD_W-1:0]    ridx;

    assign waddr = wdata_i[WORD_BITS +: ADDR_W];
    assign ridx  = RD_W'(rd_idx_i);

    always_comb begin
        mem_d = mem_q;
        if (wr_i && wdata_i[STROBE_BIT] && (int'(waddr) < int'(NWORDS))) begin
            mem_d[waddr * WORD_BITS +: WORD_BITS] = wdata_i[WORD_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_bit_o = mem_q[ridx];

endmodule

// File: rtl/ovl_index.sv
module ovl_index #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i) begin
            idx_d = '0;
        end else if (adv_i) begin
            idx_d = (idx_q >= last_i) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/ovl_overlay_unit.sv
module ovl_overlay_unit #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned WORD_BITS  = 20,
    parameter int unsigned STROBE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              epoch_i,
    output logic              ovl_en_o,
    output logic              ovl_sgn0_o,
    output logic              ovl_sgn1_o
);
    import ovl_pkg::*;

    localparam int unsigned MAX_LEN  = 1 << LEN_W;
    localparam int unsigned NWORDS   = (MAX_LEN + WORD_BITS - 1) / WORD_BITS;
    localparam int unsigned ADDR_W   = $clog2(NWORDS);
    localparam int unsigned LEN1_LSB = 8;

    typedef struct packed {
        logic                           en;
        logic [NUM_CODES-1:0][LEN_W-1:0] last;
        logic [NUM_CODES-1:0]            sgn;
    } state_t;

    state_t st_d, st_q;

    logic                             ctrl_wr, len_wr, clr, adv;
    logic [NUM_CODES-1:0]             code_wr;
    logic [NUM_CODES-1:0]             code_bit;
    logic [NUM_CODES-1:0][LEN_W-1:0]  idx;

    assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign len_wr  = wr_en_i && (wr_sel_i == SEL_LEN);
    assign clr     = ctrl_wr && wr_data_i[CTRL_CLR_BIT];
    assign adv     = epoch_i && st_q.en;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        assign code_wr[g] = wr_en_i && (wr_sel_i == 2'(int'(SEL_CODE0) + g));

        ovl_code_store #(
            .DATA_W     (DATA_W),
            .WORD_BITS  (WORD_BITS),
            .NWORDS     (NWORDS),
            .ADDR_W     (ADDR_W),
            .STROBE_BIT (STROBE_BIT),
            .IDX_W      (LEN_W)
        ) i_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (code_wr[g]),
            .wdata_i  (wr_data_i),
            .rd_idx_i (idx[g]),
            .rd_bit_o (code_bit[g])
        );

        ovl_index #(
            .IDX_W (LEN_W)
        ) i_index (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .adv_i  (adv),
            .last_i (st_q.last[g]),
            .idx_o  (idx[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (len_wr) begin
            st_d.last[0] = wr_data_i[LEN_W-1:0];
            st_d.last[1] = wr_data_i[LEN1_LSB +: LEN_W];
        end
        if (adv) begin
            st_d.sgn = code_bit;
        end
        if (ctrl_wr) begin
            st_d.en = wr_data_i[CTRL_EN_BIT];
            if (clr) begin
                st_d.sgn = '0;
            end
        end
        if (!st_d.en) begin
            st_d.sgn = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovl_en_o   = st_q.en;
    assign ovl_sgn0_o = st_q.sgn[0];
    assign ovl_sgn1_o = st_q.sgn[1];

endmodule

// File: rtl/ovl_overlay_chk.sv
module ovl_overlay_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              epoch_i,
    input logic              ovl_en_o,
    input logic              ovl_sgn0_o,
    input logic              ovl_sgn1_o
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en_i && (wr_sel_i == 2'd0);

    // R8
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_en_o |-> (!ovl_sgn0_o && !ovl_sgn1_o));

    // R8
    off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data_i[0]) |=> !ovl_en_o);

    // R6
    clear_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data_i[1:0] == 2'b11) |=> (ovl_en_o && !ovl_sgn0_o && !ovl_sgn1_o));

    // R9
    sgn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!epoch_i && !ctrl_wr) |=> ($stable(ovl_sgn0_o) && $stable(ovl_sgn1_o)));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ovl_en_o));

endmodule

bind ovl_overlay_unit ovl_overlay_chk #(.DATA_W(DATA_W)) u_ovl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .epoch_i    (epoch_i),
    .ovl_en_o   (ovl_en_o),
    .ovl_sgn0_o (ovl_sgn0_o),
    .ovl_sgn1_o (ovl_sgn1_o)
);

// File: tb/test_ovl_overlay_unit.sv
module test_ovl_overlay_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        epoch = 1'b0;
    logic        ovl_en, sgn0, sgn1;

    always #5 clk = ~clk;

    ovl_overlay_unit i_ovl_overlay_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .epoch_i    (epoch),
        .ovl_en_o   (ovl_en),
        .ovl_sgn0_o (sgn0),
        .ovl_sgn1_o (sgn1)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // bench model, built from the requirements
    logic m0 [0:259];
    logic m1 [0:259];
    int   mlast0 = 0, mlast1 = 0, midx0 = 0, midx1 = 0;
    logic men = 1'b0, ms0 = 1'b0, ms1 = 1'b0;

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] data;
        logic [7:0]  neps;
    } vec_t;

    // lengths 45/7, clear+on, off, on, clear+on, lengths 20/1, clear+on
    localparam vec_t VECS [0:6] = '{
        '{2'd1, 32'h0000_062C, 8'd0},
        '{2'd0, 32'h0000_0003, 8'd50},
        '{2'd0, 32'h0000_0000, 8'd3},
        '{2'd0, 32'h0000_0001, 8'd10},
        '{2'd0, 32'h0000_0003, 8'd5},
        '{2'd1, 32'h0000_0013, 8'd0},
        '{2'd0, 32'h0000_0003, 8'd25}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pat(input int seed, input int pos);
        return ((pos * seed + pos / 3) % 5) < 2;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: begin
                men = d[0];
                if (d[1]) begin midx0 = 0; midx1 = 0; ms0 = 0; ms1 = 0; end
                if (!men) begin ms0 = 0; ms1 = 0; end
                chk("R6/R7/R8 enable after control write", {31'd0, ovl_en}, {31'd0, men});
            end
            2'd1: begin mlast0 = int'(d[7:0]); mlast1 = int'(d[15:8]); end
            default: begin
                if (d[31] && d[23:20] < 4'd13) begin
                    for (int k = 0; k < 20; k++) begin
                        if (sel == 2'd2) m0[int'(d[23:20]) * 20 + k] = d[k];
                        else             m1[int'(d[23:20]) * 20 + k] = d[k];
                    end
                end
            end
        endcase
    endtask

    task automatic ep(input string tag);
        epoch = 1'b1;
        @(negedge clk);
        epoch = 1'b0;
        if (men) begin
            ms0 = m0[midx0];
            ms1 = m1[midx1];
            midx0 = (midx0 >= mlast0) ? 0 : midx0 + 1;
            midx1 = (midx1 >= mlast1) ? 0 : midx1 + 1;
        end
        chk(tag, {30'd0, sgn1, sgn0}, {30'd0, ms1, ms0});
    endtask

    task automatic load(input int which, input int len, input int seed);
        for (int w = 0; w < (len + 19) / 20; w++) begin
            logic [31:0] d;
            d = 32'd0;
            for (int k = 0; k < 20; k++) begin
                if (w * 20 + k < len) d[k] = pat(seed, w * 20 + k);
            end
            d[23:20] = 4'(w);
            d[31] = 1'b1;
            wr(2'(2 + which), d);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 260; i++) begin m0[i] = 1'b0; m1[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 reset enable", {31'd0, ovl_en}, 32'd0);
        chk("R1 reset signs", {30'd0, sgn1, sgn0}, 32'd0);
        // R8: epoch while off has no effect
        ep("R8 epoch while off");

        // R1: default one-chip lengths; R3 chip 0 in bit 0
        wr(2'd2, 32'h8000_0001);
        wr(2'd0, 32'h0000_0003);
        chk("R6 signs cleared", {30'd0, sgn1, sgn0}, 32'd0);
        for (int i = 0; i < 3; i++) ep("R1 R3 one-chip default length");

        // R3 R5: code 0 of 45 chips (last word partial), code 1 of 7 chips
        load(0, 45, 7);
        load(1, 7, 3);

        // table walk: R2 R6 R7 R8 R9 R10 R11
        foreach (VECS[v]) begin
            wr(VECS[v].sel, VECS[v].data);
            for (int e = 0; e < int'(VECS[v].neps); e++) begin
                ep("R9 R10 R11 table epoch");
            end
        end

        // R4: unstrobed and out-of-range words ignored
        wr(2'd2, 32'h000F_FFFF);
        wr(2'd3, 32'h0000_FFFF);
        wr(2'd2, 32'h80DF_FFFF);
        wr(2'd0, 32'h0000_0003);
        for (int e = 0; e < 22; e++) ep("R4 ignored words");

        // R5 R10: code 0 of 40 chips (two full words), code 1 of 3 chips
        load(0, 40, 11);
        wr(2'd1, 32'h0000_0227);
        wr(2'd0, 32'h0000_0003);
        for (int e = 0; e < 45; e++) ep("R5 R10 full last word wrap");

        // R8: off in the middle of a run
        wr(2'd0, 32'h0000_0000);
        chk("R8 signs zero when off", {30'd0, sgn1, sgn0}, 32'd0);
        for (int e = 0; e < 2; e++) ep("R8 off ignores epoch");
        // R7: resume continues the sequence
        wr(2'd0, 32'h0000_0001);
        for (int e = 0; e < 6; e++) ep("R7 resume keeps indices");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule